// File: doc/BRIEF.md
# Dual-Format Palette Color Lookup

This block turns pixel values into drive codes for the video DACs of a retro display controller. It holds a small table of writable color entries. In palette mode the low bits of each pixel pick one table entry. The same six entry bits are read in one of two ways, chosen by the output format: as three 2-bit red, green and blue levels for an RGB monitor, or as a 2-bit intensity and a 4-bit hue phase for a composite encoder.

A direct-color mode skips the table. An 8-bit pixel is split straight into the three 3-bit DAC codes, which gives 256 colors out of a 512-color space. Any DAC bit that has no source bit is driven as zero.

The output is registered and is black during blanking. The format and the direct-color selection come from static control inputs. The block takes them up only on a line-start pulse, so the mapping never changes in the middle of a scan line.

Top module: `pal_lookup`

## Requirements
- R1: After reset every table entry is zero, the adopted mode is RGB palette mode, and all outputs are zero.
- R2: A palette write (wr_en with wr_addr and wr_data) changes the entry at the clock edge. A pixel presented in the same cycle as the write still sees the old entry, and a pixel presented in the following cycle sees the new one.
- R3: In RGB palette mode an entry is split as entry[5:4] red, entry[3:2] green and entry[1:0] blue. Each 2-bit field becomes a DAC code of {field, 1'b0}, and the composite outputs are zero.
- R4: In composite palette mode (format input 1) entry[5:4] drives the intensity output and entry[3:0] drives the phase output, and all three RGB DAC codes are zero.
- R5: In direct-color mode the pixel drives the DACs without the table: red = pixel[7:5], green = pixel[4:2] and blue = {pixel[1:0], 1'b0}. The composite outputs are zero, whatever the format.
- R6: In palette mode only pixel[3:0] selects the entry, and pixel[7:4] has no effect on the outputs.
- R7: The outputs show the result for the inputs of the previous clock edge, which is one cycle of latency.
- R8: When blank is high at an edge, every output is zero after that edge.
- R9: The format and direct-color inputs are adopted only in a cycle with line_start high, and they apply to that cycle's pixel and to every later pixel until the next line_start. Changes without line_start have no effect.
- R10: The RGB DAC outputs and the composite outputs are never nonzero at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Palette write strobe |
| wr_addr | input | 4 | Palette entry to write |
| wr_data | input | 6 | New entry value |
| fmt_comp | input | 1 | Format select: 0 RGB, 1 composite |
| direct_en | input | 1 | Direct-color mode select |
| line_start | input | 1 | Adopt the format and direct-color inputs this cycle |
| blank | input | 1 | Force black |
| pixel | input | 8 | Pixel value (palette index or direct color) |
| dac_r | output | 3 | Red DAC code |
| dac_g | output | 3 | Green DAC code |
| dac_b | output | 3 | Blue DAC code |
| comp_int | output | 2 | Composite intensity |
| comp_phase | output | 4 | Composite hue phase |

## Verification
The bench puts the same entries through both formats to show that one bit pattern decodes two ways. If the field order were swapped, or the zero LSB were placed at the wrong end, the DAC codes would come out shuffled or doubled.

It presents a write and a read of the same entry in back-to-back cycles. A table with a write-through path would show the new color one cycle too early.

It moves the control inputs in the middle of a line and checks that the mapping holds until line_start. It also sets the upper pixel bits in palette mode, where a design that decoded them would select the wrong entry.

Blanking and a reset after the table is loaded must both give black and a cleared table.

// File: rtl/pal_pkg.sv
package pal_pkg;
    localparam int unsigned ENTRY_BITS = 6;
    localparam int unsigned DAC_BITS   = 3;
    localparam int unsigned INT_BITS   = 2;
    localparam int unsigned PHASE_BITS = 4;
    localparam int unsigned PIX_BITS   = 8;

    typedef enum logic {
        FMT_RGB  = 1'b0,
        FMT_COMP = 1'b1
    } fmt_e;

    typedef struct packed {
        logic [DAC_BITS-1:0]   r;
        logic [DAC_BITS-1:0]   g;
        logic [DAC_BITS-1:0]   b;
        logic [INT_BITS-1:0]   inten;
        logic [PHASE_BITS-1:0] phase;
    } drive_t;

    typedef struct packed {
        fmt_e fmt;
        logic direct;
    } mode_t;
endpackage

// File: rtl/pal_mode_ctl.sv
module pal_mode_ctl
    import pal_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  line_start,
    input  logic  fmt_in,
    input  logic  direct_in,
    output mode_t mode_eff
);
    mode_t mode_d, mode_q;

    always_comb begin
        mode_d = mode_q;
        if (line_start) begin
            mode_d.fmt    = fmt_e'(fmt_in);
            mode_d.direct = direct_in;
        end
        mode_eff = mode_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= '{fmt: FMT_RGB, direct: 1'b0};
        else        mode_q <= mode_d;
    end

    // R9: without a line-start pulse the adopted mode must not move
    assert_mode_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !line_start |=> $stable(mode_q));
endmodule

// File: rtl/pal_regfile.sv
module pal_regfile #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned WIDTH = 6,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [AW-1:0]    rd_idx,
    output logic [WIDTH-1:0] rd_data
);
    logic [WIDTH-1:0] ent_d [DEPTH];
    logic [WIDTH-1:0] ent_q [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            ent_d[i] = ent_q[i];
        end
        if (wr_en) ent_d[wr_addr] = wr_data;
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!rst_n) ent_q[i] <= '0;
            else        ent_q[i] <= ent_d[i];
        end
    end

    assign rd_data = ent_q[rd_idx];

    // R2: a write lands in the addressed entry at the edge
    assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ent_q[$past(wr_addr)] == $past(wr_data));
endmodule

// File: rtl/pal_decode.sv
module pal_decode
    import pal_pkg::*;
(
    input  logic [ENTRY_BITS-1:0] entry,
    input  logic [PIX_BITS-1:0]   pixel,
    input  mode_t                 mode,
    input  logic                  blank,
    output drive_t                drive
);
    localparam int unsigned FLD   = ENTRY_BITS / 3;
    localparam int unsigned PAD   = DAC_BITS - FLD;
    localparam int unsigned DB_W  = PIX_BITS - 2 * DAC_BITS;
    localparam int unsigned DPAD  = DAC_BITS - DB_W;

    always_comb begin
        drive = '0;
        if (blank) begin
            drive = '0;
        end else if (mode.direct) begin
            drive.r = pixel[PIX_BITS-1 -: DAC_BITS];
            drive.g = pixel[PIX_BITS-1-DAC_BITS -: DAC_BITS];
            drive.b = {pixel[DB_W-1:0], {DPAD{1'b0}}};
        end else if (mode.fmt == FMT_COMP) begin
            drive.inten = entry[ENTRY_BITS-1 -: INT_BITS];
            drive.phase = entry[PHASE_BITS-1:0];
        end else begin
            drive.r = {entry[3*FLD-1 -: FLD], {PAD{1'b0}}};
            drive.g = {entry[2*FLD-1 -: FLD], {PAD{1'b0}}};
            drive.b = {entry[FLD-1:0],        {PAD{1'b0}}};
        end
    end
endmodule

// File: rtl/pal_lookup.sv
module pal_lookup
    import pal_pkg::*;
#(
    parameter int unsigned ENTRIES = 16,
    localparam int unsigned IW     = $clog2(ENTRIES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [IW-1:0]         wr_addr,
    input  logic [ENTRY_BITS-1:0] wr_data,
    input  logic                  fmt_comp,
    input  logic                  direct_en,
    input  logic                  line_start,
    input  logic                  blank,
    input  logic [PIX_BITS-1:0]   pixel,
    output logic [DAC_BITS-1:0]   dac_r,
    output logic [DAC_BITS-1:0]   dac_g,
    output logic [DAC_BITS-1:0]   dac_b,
    output logic [INT_BITS-1:0]   comp_int,
    output logic [PHASE_BITS-1:0] comp_phase
);
    mode_t                 mode_eff;
    logic [ENTRY_BITS-1:0] entry;
    drive_t                drive_d, drive_q;

    pal_mode_ctl u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_start (line_start),
        .fmt_in     (fmt_comp),
        .direct_in  (direct_en),
        .mode_eff   (mode_eff)
    );

    pal_regfile #(.DEPTH(ENTRIES), .WIDTH(ENTRY_BITS)) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_idx  (pixel[IW-1:0]),
        .rd_data (entry)
    );

    pal_decode u_dec (
        .entry (entry),
        .pixel (pixel),
        .mode  (mode_eff),
        .blank (blank),
        .drive (drive_d)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) drive_q <= '0;
        else        drive_q <= drive_d;
    end

    assign dac_r      = drive_q.r;
    assign dac_g      = drive_q.g;
    assign dac_b      = drive_q.b;
    assign comp_int   = drive_q.inten;
    assign comp_phase = drive_q.phase;

    // R8: blanking yields black on the next cycle
    assert_blank_black_R8: assert property (@(posedge clk) disable iff (!rst_n)
        blank |=> (dac_r == '0 && dac_g == '0 && dac_b == '0
                   && comp_int == '0 && comp_phase == '0));

    // R3: palette mode never sets a DAC LSB
    assert_pal_lsb_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_eff.direct |=> (dac_r[0] == 1'b0 && dac_g[0] == 1'b0 && dac_b[0] == 1'b0));

    // R5: direct color has no blue LSB source and silences composite
    assert_direct_shape_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mode_eff.direct |=> (dac_b[0] == 1'b0 && comp_int == '0 && comp_phase == '0));

    // R10: the two output groups are exclusive
    assert_groups_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (comp_int != '0 || comp_phase != '0) |-> (dac_r == '0 && dac_g == '0 && dac_b == '0));
endmodule

// File: tb/test_pal_lookup.sv
module test_pal_lookup;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 11;
    // vector: {fmt, direct, blank, pixel[8], exp r3 g3 b3 i2 p4}
    localparam logic [25:0] VECS [NVEC] = '{
        {1'b0,1'b0,1'b0,8'h01, 3'b100,3'b010,3'b110,2'b00,4'b0000}, // R3
        {1'b0,1'b0,1'b0,8'hF1, 3'b100,3'b010,3'b110,2'b00,4'b0000}, // R6
        {1'b0,1'b0,1'b0,8'h02, 3'b110,3'b000,3'b010,2'b00,4'b0000}, // R3
        {1'b0,1'b0,1'b0,8'h0F, 3'b010,3'b100,3'b100,2'b00,4'b0000}, // R3
        {1'b1,1'b0,1'b0,8'h01, 3'b000,3'b000,3'b000,2'b10,4'b0111}, // R4
        {1'b1,1'b0,1'b0,8'h0F, 3'b000,3'b000,3'b000,2'b01,4'b1010}, // R4
        {1'b1,1'b0,1'b0,8'h32, 3'b000,3'b000,3'b000,2'b11,4'b0001}, // R4 R6
        {1'b0,1'b1,1'b0,8'hAE, 3'b101,3'b011,3'b100,2'b00,4'b0000}, // R5
        {1'b1,1'b1,1'b0,8'hFF, 3'b111,3'b111,3'b110,2'b00,4'b0000}, // R5
        {1'b0,1'b0,1'b1,8'h01, 3'b000,3'b000,3'b000,2'b00,4'b0000}, // R8
        {1'b0,1'b0,1'b0,8'h03, 3'b000,3'b000,3'b000,2'b00,4'b0000}  // R3
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [5:0] wr_data = '0;
    logic       fmt_comp = 1'b0;
    logic       direct_en = 1'b0;
    logic       line_start = 1'b0;
    logic       blank = 1'b0;
    logic [7:0] pixel = '0;
    logic [2:0] dac_r, dac_g, dac_b;
    logic [1:0] comp_int;
    logic [3:0] comp_phase;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pal_lookup i_pal_lookup (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .fmt_comp(fmt_comp), .direct_en(direct_en), .line_start(line_start),
        .blank(blank), .pixel(pixel), .dac_r(dac_r), .dac_g(dac_g), .dac_b(dac_b),
        .comp_int(comp_int), .comp_phase(comp_phase)
    );

    task automatic check(input string req, input logic [14:0] exp);
        logic [14:0] act;
        act = {dac_r, dac_g, dac_b, comp_int, comp_phase};
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // drive at a falling edge, let one rising edge pass, return at the next falling edge
    task automatic cyc(input logic ls, input logic f, input logic d,
                       input logic b, input logic [7:0] px);
        line_start = ls; fmt_comp = f; direct_en = d; blank = b; pixel = px;
        @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [5:0] v);
        wr_en = 1'b1; wr_addr = a; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        check("R1 reset outputs", 15'd0);
        rst_n = 1'b1;
        cyc(1'b1, 1'b0, 1'b0, 1'b0, 8'h01);
        check("R1 table cleared", 15'd0);

        wr(4'd1, 6'b10_01_11);
        wr(4'd2, 6'b11_00_01);
        wr(4'd15, 6'b01_10_10);

        for (int i = 0; i < NVEC; i++) begin
            cyc(1'b1, VECS[i][25], VECS[i][24], VECS[i][23], VECS[i][22:15]);
            check($sformatf("R3/R4/R5/R6/R8/R10 vector %0d", i), VECS[i][14:0]);
        end

        // R2: a read in the write cycle sees the old entry, the next cycle sees the new one
        line_start = 1'b1; fmt_comp = 1'b0; direct_en = 1'b0; blank = 1'b0; pixel = 8'h05;
        wr_en = 1'b1; wr_addr = 4'd5; wr_data = 6'b111111;
        @(negedge clk);
        wr_en = 1'b0;
        check("R2 old value in write cycle", 15'd0);
        cyc(1'b0, 1'b0, 1'b0, 1'b0, 8'h05);
        check("R2 new value next cycle", {3'b110, 3'b110, 3'b110, 6'd0});

        // R9: control changes in the middle of a line are ignored
        cyc(1'b1, 1'b0, 1'b0, 1'b0, 8'h01);
        cyc(1'b0, 1'b1, 1'b0, 1'b0, 8'h01);
        check("R9 format held mid-line", {3'b100, 3'b010, 3'b110, 6'd0});
        cyc(1'b0, 1'b1, 1'b1, 1'b0, 8'hAE);
        check("R9 direct held mid-line", 15'd0);
        cyc(1'b1, 1'b1, 1'b0, 1'b0, 8'h01);
        check("R9 adopted at line start", {9'd0, 2'b10, 4'b0111});
        cyc(1'b0, 1'b0, 1'b0, 1'b0, 8'h0F);
        check("R9 kept after line start", {9'd0, 2'b01, 4'b1010});

        // R7: one-cycle latency, output tracks the previous edge only
        line_start = 1'b1; fmt_comp = 1'b0; pixel = 8'h02;
        #1;
        check("R7 no combinational path", {9'd0, 2'b01, 4'b1010});
        @(negedge clk);
        check("R7 updated after one edge", {3'b110, 3'b000, 3'b010, 6'd0});

        // R1: reset after loading clears the table and the mode
        rst_n = 1'b0;
        cyc(1'b1, 1'b1, 1'b1, 1'b0, 8'hFF);
        check("R1 reset mid-run outputs", 15'd0);
        rst_n = 1'b1;
        cyc(1'b0, 1'b1, 1'b1, 1'b0, 8'h01);
        check("R1 reset clears table and mode", 15'd0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule